// File: doc/BRIEF.md
# Line-Invalidate Store Backup Buffer

This block keeps an ordered log of stores that a cache-allocating store has placed into cacheable lines. Each logged entry carries the full store address and the 32-bit value. The log exists so that, if a cache line is later invalidated without being written back, the stores that landed in it can still reach memory.

Three single-cycle strobes drive it. A record strobe appends an entry, but only when its cacheable flag is set. A line-invalidate strobe selects every logged entry whose address falls in the same 32-byte line as the strobe address. Those entries are sent out, oldest first, on a valid/ready memory write port and then removed. The entries that did not match stay in the log in their original order. A discard strobe clears the whole log in one cycle.

While a drain is in progress the block raises `busy` and accepts no strobe. If more than one strobe arrives in the same idle cycle, discard wins over invalidate, and invalidate wins over record. The log depth is a parameter. A cacheable record that arrives when the log is full is dropped and raises `overflow` for one cycle.

Top module: `lineinv_backup_buf`

## Requirements
- R1: A record strobe with `rec_cacheable` low is ignored. It adds no entry, so a later invalidate of that line issues no write. When the log is full it does not raise `overflow`.
- R2: Each write-back carries exactly the 32-bit address and the 32-bit data of the record that created the entry.
- R3: An invalidate selects an entry when address bits [31:5] of the entry equal bits [31:5] of `inv_addr`. The low five bits are ignored, and an entry in the adjacent line is not selected.
- R4: A discard strobe, accepted while idle, empties the log, so no later invalidate finds any earlier entry.
- R5: The selected entries are written out in arrival order, one per `wr_valid && wr_ready` cycle. After that they are gone, and a repeated invalidate of the same line writes nothing.
- R6: Entries that are not selected stay in the log with their relative order unchanged.
- R7: `busy` and `wr_valid` rise in the cycle after an invalidate that selects at least one entry is accepted. They fall in the cycle after the last write handshake. While `wr_ready` is low, `wr_addr` and `wr_data` hold their values. An invalidate that selects nothing leaves `busy` low.
- R8: A cacheable record that arrives while the log holds DEPTH entries is dropped. `overflow` is high for exactly the one cycle after it, and the log keeps its entries.
- R9: While `busy` is high, the record, invalidate and discard strobes have no effect.
- R10: A synchronous active-high reset empties the log. After it, `busy`, `wr_valid` and `overflow` are low.
- R11: When strobes coincide in an idle cycle, discard takes precedence over invalidate, and invalidate takes precedence over record. The strobes that lose are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rec_valid | input | 1 | Record strobe |
| rec_addr | input | 32 | Address of the store to log |
| rec_data | input | 32 | Data of the store to log |
| rec_cacheable | input | 1 | Store target is cacheable |
| inv_valid | input | 1 | Line-invalidate strobe |
| inv_addr | input | 32 | Any address inside the line to invalidate |
| discard_valid | input | 1 | Clear-all strobe |
| wr_valid | output | 1 | Write-back request valid |
| wr_ready | input | 1 | Memory accepts the write-back |
| wr_addr | output | 32 | Write-back address |
| wr_data | output | 32 | Write-back data |
| busy | output | 1 | Drain in progress; strobes are ignored |
| overflow | output | 1 | One-cycle pulse: a cacheable record was dropped because the log was full |

## Verification
Internal state shows at the ports only at particular moments. A corrupted entry, a lost entry or a wrongly ordered entry appears at the next invalidate of its line, as a wrong write address or data, or as a wrong number of write handshakes. A broken compaction therefore shows up only when a later invalidate targets one of the entries that were kept. For this reason the tests invalidate every surviving line afterwards. A wrong count appears as a missing or spurious `overflow` pulse at the record that fills the log. A wrong pending mask appears within one cycle, as `busy` staying high or as a write to the wrong line.

// File: rtl/lbb_pkg.sv
package lbb_pkg;

   typedef enum logic [1:0] {
      LBB_CMD_NONE    = 2'd0,
      LBB_CMD_DISCARD = 2'd1,
      LBB_CMD_INVAL   = 2'd2,
      LBB_CMD_RECORD  = 2'd3
   } lbb_cmd_e;

   // Idle-cycle arbitration: clear-all beats line invalidate beats append.
   function automatic lbb_cmd_e lbb_arbitrate(input logic idle,
                                              input logic disc,
                                              input logic inv,
                                              input logic rec_ok);
      if (!idle)        return LBB_CMD_NONE;
      else if (disc)    return LBB_CMD_DISCARD;
      else if (inv)     return LBB_CMD_INVAL;
      else if (rec_ok)  return LBB_CMD_RECORD;
      else              return LBB_CMD_NONE;
   endfunction

endpackage

// File: rtl/lbb_line_cmp.sv
module lbb_line_cmp #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 5
) (
   input  logic [ADDR_W-1:0] ent_addr [DEPTH],
   input  logic [DEPTH-1:0]  ent_live,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic [DEPTH-1:0]  hit
);
   localparam int LINE_W = ADDR_W - OFF_W;

   logic [LINE_W-1:0] probe_line;
   assign probe_line = probe_addr[ADDR_W-1:OFF_W];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit[g] = ent_live[g] && (ent_addr[g][ADDR_W-1:OFF_W] == probe_line);
   end

endmodule

// File: rtl/lbb_first_pick.sv
module lbb_first_pick #(
   parameter int DEPTH = 8,
   parameter int IDX_W = 3
) (
   input  logic [DEPTH-1:0] req,
   output logic [IDX_W-1:0] idx,
   output logic [DEPTH-1:0] onehot
);
   always_comb begin
      idx    = '0;
      onehot = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = IDX_W'(i);
         end
      end
      if (|req) begin
         onehot[idx] = 1'b1;
      end
   end

endmodule

// File: rtl/lbb_compact.sv
module lbb_compact #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 3
) (
   input  logic [DEPTH-1:0]  keep,
   input  logic [ADDR_W-1:0] in_addr  [DEPTH],
   input  logic [DATA_W-1:0] in_data  [DEPTH],
   output logic [ADDR_W-1:0] out_addr [DEPTH],
   output logic [DATA_W-1:0] out_data [DEPTH]
);
   logic [IDX_W-1:0] slot;

   // Stable squeeze: the k-th kept source lands in slot k.
   always_comb begin
      slot = '0;
      for (int i = 0; i < DEPTH; i++) begin
         out_addr[i] = '0;
         out_data[i] = '0;
      end
      for (int i = 0; i < DEPTH; i++) begin
         if (keep[i]) begin
            out_addr[slot] = in_addr[i];
            out_data[slot] = in_data[i];
            slot           = slot + 1'b1;
         end
      end
   end

endmodule

// File: rtl/lineinv_backup_buf.sv
module lineinv_backup_buf
   import lbb_pkg::*;
#(
   parameter int DEPTH      = 8,
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rec_valid,
   input  logic [ADDR_W-1:0] rec_addr,
   input  logic [DATA_W-1:0] rec_data,
   input  logic              rec_cacheable,
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_addr,
   input  logic              discard_valid,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              overflow
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int LINE_W = ADDR_W - OFF_W;
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W  = $clog2(DEPTH + 1);

   // elaboration checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("lineinv_backup_buf: DEPTH must be at least 2");
   end
   if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line
      $error("lineinv_backup_buf: LINE_BYTES must be a power of two");
   end
   if (OFF_W >= ADDR_W) begin : g_bad_addr
      $error("lineinv_backup_buf: line offset wider than address");
   end

   logic [ADDR_W-1:0] ent_addr_q [DEPTH];
   logic [DATA_W-1:0] ent_data_q [DEPTH];
   logic [ADDR_W-1:0] sq_addr    [DEPTH];
   logic [DATA_W-1:0] sq_data    [DEPTH];
   logic [CNT_W-1:0]  count_q;
   logic [DEPTH-1:0]  pend_q;
   logic [DEPTH-1:0]  kill_q;
   logic [LINE_W-1:0] line_q;
   logic              ovf_q;

   logic [DEPTH-1:0]  live;
   logic [DEPTH-1:0]  hit;
   logic [DEPTH-1:0]  cur_oh;
   logic [IDX_W-1:0]  cur_idx;
   logic              full;
   logic              beat;
   logic              last_beat;
   lbb_cmd_e          cmd;

   for (genvar g = 0; g < DEPTH; g++) begin : g_live
      assign live[g] = (CNT_W'(g) < count_q);
   end

   assign full = (count_q == CNT_W'(DEPTH));
   assign busy = |pend_q;
   assign cmd  = lbb_arbitrate(!busy, discard_valid, inv_valid,
                               rec_valid && rec_cacheable);

   lbb_line_cmp #(
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W),
      .OFF_W (OFF_W)
   ) u_cmp (
      .ent_addr  (ent_addr_q),
      .ent_live  (live),
      .probe_addr(inv_addr),
      .hit       (hit)
   );

   lbb_first_pick #(
      .DEPTH(DEPTH),
      .IDX_W(IDX_W)
   ) u_pick (
      .req   (pend_q),
      .idx   (cur_idx),
      .onehot(cur_oh)
   );

   lbb_compact #(
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .IDX_W (IDX_W)
   ) u_sq (
      .keep    (live & ~kill_q),
      .in_addr (ent_addr_q),
      .in_data (ent_data_q),
      .out_addr(sq_addr),
      .out_data(sq_data)
   );

   assign wr_valid  = busy;
   assign wr_addr   = ent_addr_q[cur_idx];
   assign wr_data   = ent_data_q[cur_idx];
   assign overflow  = ovf_q;
   assign beat      = wr_valid && wr_ready;
   assign last_beat = beat && ((pend_q & ~cur_oh) == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q <= '0;
         pend_q  <= '0;
         kill_q  <= '0;
         line_q  <= '0;
         ovf_q   <= 1'b0;
         for (int i = 0; i < DEPTH; i++) begin
            ent_addr_q[i] <= '0;
            ent_data_q[i] <= '0;
         end
      end else begin
         ovf_q <= 1'b0;
         if (busy) begin
            if (beat) begin
               pend_q <= pend_q & ~cur_oh;
            end
            if (last_beat) begin
               for (int i = 0; i < DEPTH; i++) begin
                  ent_addr_q[i] <= sq_addr[i];
                  ent_data_q[i] <= sq_data[i];
               end
               count_q <= count_q - CNT_W'($countones(kill_q));
               kill_q  <= '0;
            end
         end else begin
            case (cmd)
               LBB_CMD_DISCARD: begin
                  count_q <= '0;
               end
               LBB_CMD_INVAL: begin
                  pend_q <= hit;
                  kill_q <= hit;
                  line_q <= inv_addr[ADDR_W-1:OFF_W];
               end
               LBB_CMD_RECORD: begin
                  if (full) begin
                     ovf_q <= 1'b1;
                  end else begin
                     ent_addr_q[count_q[IDX_W-1:0]] <= rec_addr;
                     ent_data_q[count_q[IDX_W-1:0]] <= rec_data;
                     count_q <= count_q + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // ---------------------------------------------------------------
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R7
   AST_WR_LINE: assert property (@(posedge clk) disable iff (rst)
      wr_valid |-> (wr_addr[ADDR_W-1:OFF_W] == line_q)); // R3
   AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
      count_q <= CNT_W'(DEPTH)); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      overflow |-> ($past(count_q) == CNT_W'(DEPTH) && $stable(count_q))); // R8
   AST_DISCARD_EMPTY: assert property (@(posedge clk) disable iff (rst)
      (discard_valid && !busy) |=> (count_q == '0)); // R4
   AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
      (busy && !(wr_valid && wr_ready)) |=> ($stable(count_q) && busy)); // R9

endmodule

// File: tb/lineinv_backup_buf_bench.sv
module lineinv_backup_buf_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;

   logic        clk = 1'b0;
   logic        rst;
   logic        rec_valid, rec_cacheable, inv_valid, discard_valid, wr_ready;
   logic [31:0] rec_addr, rec_data, inv_addr;
   logic        wr_valid, busy, overflow;
   logic [31:0] wr_addr, wr_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [31:0] mq_a [$];
   logic [31:0] mq_d [$];

   lineinv_backup_buf #(.DEPTH(DEPTH)) u_lineinv_backup_buf (
      .clk(clk), .rst(rst),
      .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_data(rec_data),
      .rec_cacheable(rec_cacheable),
      .inv_valid(inv_valid), .inv_addr(inv_addr),
      .discard_valid(discard_valid),
      .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .overflow(overflow)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog R5: actual=hung expected=run completes");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      rec_valid = 0; rec_cacheable = 0; rec_addr = '0; rec_data = '0;
      inv_valid = 0; inv_addr = '0; discard_valid = 0; wr_ready = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle_inputs();
      rst = 1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst = 0;
      mq_a.delete(); mq_d.delete();
   endtask

   task automatic do_rec(input logic [31:0] a, input logic [31:0] d, input logic c);
      logic exp_ovf;
      exp_ovf = c && (mq_a.size() == DEPTH);
      if (c && !exp_ovf) begin mq_a.push_back(a); mq_d.push_back(d); end
      @(negedge clk);
      rec_valid = 1; rec_addr = a; rec_data = d; rec_cacheable = c;
      @(posedge clk);
      @(negedge clk);
      rec_valid = 0; rec_cacheable = 0;
      chk("R8 overflow pulse after record", {31'b0, overflow}, {31'b0, exp_ovf});
   endtask

   // Invalidate a line and collect write-backs.
   // stall: toggle wr_ready; disturb: pulse other strobes while busy;
   // with_rec: drive a record in the same cycle as the invalidate (R11).
   task automatic do_inv(input logic [31:0] a, input bit stall, input bit disturb,
                         input bit with_rec);
      logic [31:0] ea [$];
      logic [31:0] ed [$];
      logic [31:0] ka [$];
      logic [31:0] kd [$];
      logic [31:0] hold_a, hold_d;
      bit          held;
      int          got;
      int          cyc;
      foreach (mq_a[i]) begin
         if (mq_a[i][31:5] == a[31:5]) begin ea.push_back(mq_a[i]); ed.push_back(mq_d[i]); end
         else begin ka.push_back(mq_a[i]); kd.push_back(mq_d[i]); end
      end
      mq_a = ka; mq_d = kd;
      @(negedge clk);
      inv_valid = 1; inv_addr = a;
      if (with_rec) begin
         rec_valid = 1; rec_cacheable = 1; rec_addr = a; rec_data = 32'hC0FF_EE00;
      end
      @(posedge clk);
      @(negedge clk);
      inv_valid = 0; rec_valid = 0; rec_cacheable = 0;
      chk("R7 busy after invalidate", {31'b0, busy}, {31'b0, ea.size() != 0});
      got = 0; cyc = 0; held = 0;
      while (busy && cyc < 200) begin
         if (held) begin
            chk("R7 wr_addr held under stall", wr_addr, hold_a);
            chk("R7 wr_data held under stall", wr_data, hold_d);
         end
         if (disturb && cyc == 0) begin
            rec_valid = 1; rec_cacheable = 1; rec_addr = a; rec_data = 32'hBAD0_0001;
            discard_valid = 1; inv_valid = 1; inv_addr = a ^ 32'h0000_1000;
         end else begin
            rec_valid = 0; rec_cacheable = 0; discard_valid = 0; inv_valid = 0;
         end
         wr_ready = !stall || (cyc % 2 == 1);
         held = 0;
         if (wr_valid && wr_ready) begin
            if (got < ea.size()) begin
               chk("R2 R5 write address in order", wr_addr, ea[got]);
               chk("R2 R5 write data in order", wr_data, ed[got]);
            end
            got++;
         end else if (wr_valid) begin
            held = 1; hold_a = wr_addr; hold_d = wr_data;
         end
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      rec_valid = 0; rec_cacheable = 0; discard_valid = 0; inv_valid = 0; wr_ready = 0;
      chk("R5 write count for line", got, ea.size());
      chk("R7 wr_valid low after drain", {31'b0, wr_valid}, 32'd0);
   endtask

   task automatic t_reset();
      chk("R10 busy after reset", {31'b0, busy}, 32'd0);
      chk("R10 wr_valid after reset", {31'b0, wr_valid}, 32'd0);
      chk("R10 overflow after reset", {31'b0, overflow}, 32'd0);
      do_inv(32'h0000_0000, 0, 0, 0);
   endtask

   task automatic t_basic();
      do_rec(32'h1000_0040, 32'hA000_0001, 1);
      do_rec(32'h1000_0060, 32'hB000_0001, 1);
      do_rec(32'h1000_0044, 32'hA000_0002, 1);
      do_rec(32'h1000_0080, 32'hC000_0001, 1);
      do_rec(32'h1000_005C, 32'hA000_0003, 1);
      do_rec(32'h1000_0064, 32'hB000_0002, 1);
      do_inv(32'h1000_0050, 0, 0, 0);   // R3 R5 three line-A entries in order
      do_inv(32'h1000_0050, 0, 0, 0);   // R5 nothing left
      do_inv(32'h1000_007F, 1, 0, 0);   // R6 R7 line B survives, stalled
      do_inv(32'h1000_0080, 0, 0, 0);   // R6
   endtask

   task automatic t_uncached();
      do_rec(32'h2000_0100, 32'h1111_1111, 0);   // R1 ignored
      do_inv(32'h2000_0100, 0, 0, 0);
   endtask

   task automatic t_boundary();
      do_rec(32'h3000_001C, 32'h3333_0001, 1);
      do_rec(32'h3000_0020, 32'h3333_0002, 1);
      do_inv(32'h3000_0000, 0, 0, 0);   // R3 only the first
      do_inv(32'h3000_003F, 0, 0, 0);   // R3 the adjacent one
   endtask

   task automatic t_overflow();
      for (int i = 0; i < DEPTH; i++) begin
         do_rec(32'h4000_0000 + 32'(i) * 32'h40, 32'h4400_0000 + 32'(i), 1);
      end
      do_rec(32'h4000_1000, 32'hDEAD_BEEF, 1);    // R8 dropped
      @(negedge clk);
      chk("R8 overflow single cycle", {31'b0, overflow}, 32'd0);
      do_rec(32'h4000_2000, 32'hDEAD_BEE0, 0);    // R1 no overflow when uncached
      do_inv(32'h4000_1000, 0, 0, 0);             // R8 dropped entry absent
      do_inv(32'h4000_00C0, 0, 0, 0);             // middle entry
      for (int i = 0; i < DEPTH; i++) begin
         do_inv(32'h4000_0000 + 32'(i) * 32'h40, 0, 0, 0);   // R6 rest intact
      end
   endtask

   task automatic t_discard();
      do_rec(32'h5000_0000, 32'h5555_0001, 1);
      do_rec(32'h5000_0004, 32'h5555_0002, 1);
      @(negedge clk);
      discard_valid = 1;
      @(posedge clk);
      @(negedge clk);
      discard_valid = 0;
      mq_a.delete(); mq_d.delete();
      do_inv(32'h5000_0000, 0, 0, 0);   // R4 nothing
   endtask

   task automatic t_busy_ignore();
      do_rec(32'h6000_0000, 32'h6666_0001, 1);
      do_rec(32'h6000_1000, 32'h6666_0002, 1);
      do_rec(32'h6000_0008, 32'h6666_0003, 1);
      do_inv(32'h6000_0000, 1, 1, 0);   // R9 strobes during drain
      do_inv(32'h6000_1000, 0, 0, 0);   // R9 discard/inv were ignored
      do_inv(32'h6000_0000, 0, 0, 0);   // R9 record was ignored
   endtask

   task automatic t_priority();
      do_rec(32'h7000_0000, 32'h7777_0001, 1);
      @(negedge clk);
      discard_valid = 1; inv_valid = 1; inv_addr = 32'h7000_0000;
      rec_valid = 1; rec_cacheable = 1; rec_addr = 32'h7000_2000; rec_data = 32'h7777_0002;
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
      chk("R11 discard wins, no drain", {31'b0, busy}, 32'd0);
      mq_a.delete(); mq_d.delete();
      do_inv(32'h7000_0000, 0, 0, 0);   // R11
      do_inv(32'h7000_2000, 0, 0, 0);   // R11 record lost
      do_rec(32'h7000_4000, 32'h7777_0003, 1);
      do_inv(32'h7000_4000, 0, 0, 1);   // R11 invalidate beats record
      do_inv(32'h7000_4000, 0, 0, 0);
   endtask

   task automatic t_mid_reset();
      do_rec(32'h8000_0000, 32'h8888_0001, 1);
      do_reset();
      chk("R10 busy after second reset", {31'b0, busy}, 32'd0);
      do_inv(32'h8000_0000, 0, 0, 0);   // R10 emptied
   endtask

   initial begin
      idle_inputs();
      rst = 1;
      do_reset();
      t_reset();
      t_basic();
      t_uncached();
      t_boundary();
      t_overflow();
      t_discard();
      t_busy_ignore();
      t_priority();
      t_mid_reset();
      repeat (3) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule